// File: doc/BRIEF.md
# Dual-Port Inter-Processor Mailbox

This block lets two processor sides, A and B, exchange 32-bit words and doorbell events. Each side has its own register port with address, write strobe, write data, read strobe, read data and one interrupt line. Both sides see the same layout. There are four transmit slots, four receive slots, a status word and a control word. A word that one side writes into its transmit slot n lands in the other side's receive slot n. Per-slot full and empty flags let both ends run a one-word handshake without polling shared memory.

A doorbell is a data-free event. Either side sets a request bit in its control word, and a pending flag rises on the other side. That flag stays set until its owner clears it by writing a one to it. A side's interrupt line is high while any status flag and its enable bit are both set. Inside every status and control field the slots run in reversed order: slot n uses bit (3 - n) of its 4-bit field.

Top module: `mbox_dual`

## Requirements
- R1: Byte offsets: transmit slot n at 4*n, receive slot n at 0x10 + 4*n, status at 0x20, control at 0x24. Transmit slots read as 0. Writes to receive slots are ignored. Any other offset, including unaligned ones, reads as 0 and ignores writes.
- R2: Status word, slot n: doorbell-pending at bit 28+(3-n), receive-full at bit 24+(3-n), transmit-empty at bit 20+(3-n). Bits 19..0 always read 0.
- R3: Control word, slot n: doorbell interrupt enable at bit 28+(3-n), receive interrupt enable at 24+(3-n), transmit interrupt enable at 20+(3-n), doorbell request at 16+(3-n). Bits 15..0 read 0 and ignore writes. A control write replaces all defined fields.
- R4: While reset is low at a clock edge, both sides go to this state: all transmit-empty flags 1, so status reads 0x00F00000; control reads 0; receive slots read 0; interrupts are low.
- R5: A write to transmit slot n takes effect at the next edge. The peer's receive slot n then holds the word, the peer's receive-full n is 1 and the writer's transmit-empty n is 0.
- R6: A read strobe on receive slot n returns the stored word in the same cycle and clears that side's receive-full n at the edge. The peer's transmit-empty n rises one edge later. If a new word for the same slot arrives in the same cycle as the read, receive-full stays 1.
- R7: A doorbell request bit written as 1 reads 1 for exactly one cycle. At the next edge it clears and the peer's doorbell-pending n sets.
- R8: Writing 1 to a doorbell-pending bit in the status word clears it. Writing 0 leaves it unchanged.
- R9: When a pending clear and a doorbell request reach the same flag in the same cycle, the flag ends up set.
- R10: A side's interrupt is high exactly when, for some slot, a status flag and its matching enable bit in that side's control word are both 1.
- R11: Both sides behave identically, with A and B swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_addr | input | ADDR_W | Side A byte address |
| a_wr | input | 1 | Side A write strobe |
| a_wdata | input | DATA_W | Side A write data |
| a_rd | input | 1 | Side A read strobe (triggers side effects) |
| a_rdata | output | DATA_W | Side A read data, combinational from address |
| a_irq | output | 1 | Side A interrupt |
| b_addr | input | ADDR_W | Side B byte address |
| b_wr | input | 1 | Side B write strobe |
| b_wdata | input | DATA_W | Side B write data |
| b_rd | input | 1 | Side B read strobe (triggers side effects) |
| b_rdata | output | DATA_W | Side B read data, combinational from address |
| b_irq | output | 1 | Side B interrupt |

## Verification
The bench builds the block with its default parameters: a 32-bit data path and a 6-bit address. With these values every defined offset and every offset past the control word can be reached, up to 0x3C, so reads and writes of unused and unaligned addresses are exercised. The 32-bit width puts all four flag fields and the request field at their real bit positions. This makes the reversed slot order visible in every status and control value the bench compares. Directed cases drive both ports in the same cycle to reach the two set-over-clear collisions and a reset in the middle of traffic.

// File: rtl/mbox_dual.sv
module mbox_dual #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_wr,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic              a_rd,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_irq,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_wr,
  input  logic [DATA_W-1:0] b_wdata,
  input  logic              b_rd,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_irq
);
  localparam int SLOTS   = 4;
  localparam int SIDES   = 2;
  localparam int TX_OFS  = 'h00;
  localparam int RX_OFS  = 'h10;
  localparam int SR_OFS  = 'h20;
  localparam int CR_OFS  = 'h24;
  localparam int DB_LSB  = 28;
  localparam int FUL_LSB = 24;
  localparam int EMP_LSB = 20;
  localparam int REQ_LSB = 16;

  function automatic logic [DATA_W-1:0] place(input logic [SLOTS-1:0] v, input int lsb);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int n = 0; n < SLOTS; n++) r[lsb + SLOTS - 1 - n] = v[n];
    return r;
  endfunction

  function automatic logic [SLOTS-1:0] pick(input logic [DATA_W-1:0] w, input int lsb);
    logic [SLOTS-1:0] v;
    for (int n = 0; n < SLOTS; n++) v[n] = w[lsb + SLOTS - 1 - n];
    return v;
  endfunction

  logic [ADDR_W-1:0] addr_s [SIDES];
  logic              wr_s   [SIDES];
  logic              rd_s   [SIDES];
  logic [DATA_W-1:0] wd_s   [SIDES];
  logic [DATA_W-1:0] rdat_s [SIDES];
  logic              irq_s  [SIDES];

  assign addr_s[0] = a_addr;  assign addr_s[1] = b_addr;
  assign wr_s[0]   = a_wr;    assign wr_s[1]   = b_wr;
  assign rd_s[0]   = a_rd;    assign rd_s[1]   = b_rd;
  assign wd_s[0]   = a_wdata; assign wd_s[1]   = b_wdata;
  assign a_rdata   = rdat_s[0];
  assign b_rdata   = rdat_s[1];
  assign a_irq     = irq_s[0];
  assign b_irq     = irq_s[1];

  logic [SLOTS-1:0]  tx_hit [SIDES];
  logic [SLOTS-1:0]  rx_hit [SIDES];
  logic              sr_hit [SIDES];
  logic              cr_hit [SIDES];

  logic [SLOTS-1:0]  emp    [SIDES];
  logic [SLOTS-1:0]  ful    [SIDES];
  logic [SLOTS-1:0]  dbp    [SIDES];
  logic [SLOTS-1:0]  req    [SIDES];
  logic [SLOTS-1:0]  en_db  [SIDES];
  logic [SLOTS-1:0]  en_rx  [SIDES];
  logic [SLOTS-1:0]  en_tx  [SIDES];
  logic [SLOTS-1:0]  drained[SIDES];
  logic [DATA_W-1:0] rx_q   [SIDES][SLOTS];
  logic [DATA_W-1:0] sr_w   [SIDES];
  logic [DATA_W-1:0] cr_w   [SIDES];

  always_comb begin
    for (int s = 0; s < SIDES; s++) begin
      sr_hit[s] = addr_s[s] == ADDR_W'(SR_OFS);
      cr_hit[s] = addr_s[s] == ADDR_W'(CR_OFS);
      for (int n = 0; n < SLOTS; n++) begin
        tx_hit[s][n] = addr_s[s] == ADDR_W'(TX_OFS + 4 * n);
        rx_hit[s][n] = addr_s[s] == ADDR_W'(RX_OFS + 4 * n);
      end
    end
  end

  always_comb begin
    for (int s = 0; s < SIDES; s++) begin
      sr_w[s] = place(dbp[s], DB_LSB) | place(ful[s], FUL_LSB) | place(emp[s], EMP_LSB);
      cr_w[s] = place(en_db[s], DB_LSB) | place(en_rx[s], FUL_LSB) |
                place(en_tx[s], EMP_LSB) | place(req[s], REQ_LSB);
      irq_s[s] = |((dbp[s] & en_db[s]) | (ful[s] & en_rx[s]) | (emp[s] & en_tx[s]));
      rdat_s[s] = '0;
      if (sr_hit[s]) rdat_s[s] = sr_w[s];
      if (cr_hit[s]) rdat_s[s] = cr_w[s];
      for (int n = 0; n < SLOTS; n++)
        if (rx_hit[s][n]) rdat_s[s] = rx_q[s][n];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SIDES; s++) begin
        emp[s]     <= '1;
        ful[s]     <= '0;
        dbp[s]     <= '0;
        req[s]     <= '0;
        en_db[s]   <= '0;
        en_rx[s]   <= '0;
        en_tx[s]   <= '0;
        drained[s] <= '0;
        for (int n = 0; n < SLOTS; n++) rx_q[s][n] <= '0;
      end
    end else begin
      for (int s = 0; s < SIDES; s++) begin
        drained[s] <= rx_hit[s] & {SLOTS{rd_s[s]}};
        if (wr_s[s] && cr_hit[s]) begin
          en_db[s] <= pick(wd_s[s], DB_LSB);
          en_rx[s] <= pick(wd_s[s], FUL_LSB);
          en_tx[s] <= pick(wd_s[s], EMP_LSB);
          req[s]   <= pick(wd_s[s], REQ_LSB);
        end else begin
          req[s]   <= '0;
        end
        for (int n = 0; n < SLOTS; n++) begin
          if (wr_s[1-s] && tx_hit[1-s][n]) begin
            rx_q[s][n] <= wd_s[1-s];
            ful[s][n]  <= 1'b1;
          end else if (rd_s[s] && rx_hit[s][n]) begin
            ful[s][n]  <= 1'b0;
          end
          if (wr_s[s] && tx_hit[s][n])
            emp[s][n] <= 1'b0;
          else if (drained[1-s][n])
            emp[s][n] <= 1'b1;
          if (req[1-s][n])
            dbp[s][n] <= 1'b1;
          else if (wr_s[s] && sr_hit[s] && wd_s[s][DB_LSB + SLOTS - 1 - n])
            dbp[s][n] <= 1'b0;
        end
      end
    end
  end
endmodule

module mbox_dual_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] a_addr,
  input logic              a_wr,
  input logic              a_irq,
  input logic [ADDR_W-1:0] b_addr,
  input logic              b_wr,
  input logic              b_rd,
  input logic              b_clr0,
  input logic [DATA_W-1:0] sr_a,
  input logic [DATA_W-1:0] sr_b,
  input logic [DATA_W-1:0] cr_a,
  input logic [DATA_W-1:0] cr_b
);
  AST_TX_FILLS_PEER: assert property (@(posedge clk) disable iff (!rst_n)
    (a_wr && a_addr == ADDR_W'('h00)) |=> (sr_b[27] && !sr_a[23])); // R5
  AST_RX_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (b_rd && b_addr == ADDR_W'('h10) && !(a_wr && a_addr == ADDR_W'('h00))) |=> !sr_b[27]); // R6
  AST_DOORBELL_RING: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_a[19] && !(a_wr && a_addr == ADDR_W'('h24))) |=> (sr_b[31] && !cr_a[19])); // R7
  AST_PENDING_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (b_wr && b_addr == ADDR_W'('h20) && b_clr0 && !cr_a[19]) |=> !sr_b[31]); // R8
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_a[19] && b_wr && b_addr == ADDR_W'('h20) && b_clr0) |=> sr_b[31]); // R9
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((sr_a & 32'h000F_FFFF) == 0) && ((sr_b & 32'h000F_FFFF) == 0) &&
    ((cr_a & 32'h0000_FFFF) == 0) && ((cr_b & 32'h0000_FFFF) == 0)); // R2
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((cr_a & 32'hFFF0_0000) == 0) |-> !a_irq); // R10
endmodule

bind mbox_dual mbox_dual_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .a_addr(a_addr), .a_wr(a_wr), .a_irq(a_irq),
  .b_addr(b_addr), .b_wr(b_wr), .b_rd(b_rd), .b_clr0(b_wdata[31]),
  .sr_a(sr_w[0]), .sr_b(sr_w[1]), .cr_a(cr_w[0]), .cr_b(cr_w[1])
);

// File: tb/mbox_dual_tb_top.sv
module mbox_dual_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  a_addr = '0, b_addr = '0;
  logic        a_wr = 1'b0, a_rd = 1'b0, b_wr = 1'b0, b_rd = 1'b0;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  logic [31:0] a_rdata, b_rdata;
  logic        a_irq, b_irq;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  mbox_dual dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_addr(a_addr), .a_wr(a_wr), .a_wdata(a_wdata), .a_rd(a_rd), .a_rdata(a_rdata), .a_irq(a_irq),
    .b_addr(b_addr), .b_wr(b_wr), .b_wdata(b_wdata), .b_rd(b_rd), .b_rdata(b_rdata), .b_irq(b_irq)
  );

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_PK = 2'd2, OP_IRQ = 2'd3;
  localparam logic SA = 1'b0, SB = 1'b1;
  localparam int NV = 50;
  localparam logic [44:0] VEC [NV] = '{
    {OP_PK,  SA, 6'h20, 32'h00F0_0000, 4'd4},  // R4
    {OP_PK,  SB, 6'h24, 32'h0000_0000, 4'd4},  // R4
    {OP_PK,  SA, 6'h10, 32'h0000_0000, 4'd4},  // R4
    {OP_IRQ, SA, 6'h00, 32'h0000_0000, 4'd4},  // R4
    {OP_WR,  SA, 6'h04, 32'hCAFE_0001, 4'd5},  // R5
    {OP_PK,  SB, 6'h20, 32'h04F0_0000, 4'd5},  // R5
    {OP_PK,  SA, 6'h20, 32'h00B0_0000, 4'd5},  // R5
    {OP_RD,  SB, 6'h14, 32'hCAFE_0001, 4'd5},  // R5
    {OP_PK,  SA, 6'h20, 32'h00B0_0000, 4'd6},  // R6
    {OP_PK,  SB, 6'h20, 32'h00F0_0000, 4'd6},  // R6
    {OP_WR,  SA, 6'h3C, 32'hFFFF_FFFF, 4'd1},  // R1
    {OP_PK,  SA, 6'h20, 32'h00F0_0000, 4'd6},  // R6
    {OP_WR,  SA, 6'h24, 32'h4000_0000, 4'd3},  // R3
    {OP_PK,  SA, 6'h24, 32'h4000_0000, 4'd3},  // R3
    {OP_IRQ, SA, 6'h00, 32'h0000_0000, 4'd10}, // R10
    {OP_WR,  SB, 6'h24, 32'h0004_0000, 4'd7},  // R7
    {OP_PK,  SB, 6'h24, 32'h0004_0000, 4'd7},  // R7
    {OP_PK,  SA, 6'h20, 32'h00F0_0000, 4'd7},  // R7
    {OP_WR,  SA, 6'h3C, 32'h0000_0000, 4'd7},  // R7
    {OP_PK,  SA, 6'h20, 32'h40F0_0000, 4'd7},  // R7
    {OP_PK,  SB, 6'h24, 32'h0000_0000, 4'd7},  // R7
    {OP_IRQ, SA, 6'h00, 32'h0000_0001, 4'd10}, // R10
    {OP_WR,  SA, 6'h20, 32'h8000_0000, 4'd8},  // R8
    {OP_PK,  SA, 6'h20, 32'h40F0_0000, 4'd8},  // R8
    {OP_WR,  SA, 6'h20, 32'h4000_0000, 4'd8},  // R8
    {OP_PK,  SA, 6'h20, 32'h00F0_0000, 4'd8},  // R8
    {OP_IRQ, SA, 6'h00, 32'h0000_0000, 4'd10}, // R10
    {OP_WR,  SB, 6'h20, 32'hFFFF_FFFF, 4'd2},  // R2
    {OP_PK,  SB, 6'h20, 32'h00F0_0000, 4'd2},  // R2
    {OP_WR,  SB, 6'h24, 32'hFFFF_FFFF, 4'd3},  // R3
    {OP_PK,  SB, 6'h24, 32'hFFFF_0000, 4'd3},  // R3
    {OP_IRQ, SB, 6'h00, 32'h0000_0001, 4'd10}, // R10
    {OP_WR,  SB, 6'h3C, 32'h0000_0000, 4'd7},  // R7
    {OP_PK,  SB, 6'h24, 32'hFFF0_0000, 4'd7},  // R7
    {OP_PK,  SA, 6'h20, 32'hF0F0_0000, 4'd7},  // R7
    {OP_WR,  SB, 6'h24, 32'h0000_0000, 4'd3},  // R3
    {OP_IRQ, SB, 6'h00, 32'h0000_0000, 4'd10}, // R10
    {OP_WR,  SA, 6'h20, 32'hF000_0000, 4'd8},  // R8
    {OP_PK,  SA, 6'h20, 32'h00F0_0000, 4'd8},  // R8
    {OP_PK,  SA, 6'h00, 32'h0000_0000, 4'd1},  // R1
    {OP_PK,  SA, 6'h28, 32'h0000_0000, 4'd1},  // R1
    {OP_PK,  SB, 6'h22, 32'h0000_0000, 4'd1},  // R1
    {OP_WR,  SB, 6'h0C, 32'h1234_5678, 4'd11}, // R11
    {OP_PK,  SA, 6'h20, 32'h01F0_0000, 4'd11}, // R11
    {OP_PK,  SB, 6'h20, 32'h00E0_0000, 4'd11}, // R11
    {OP_PK,  SA, 6'h1C, 32'h1234_5678, 4'd11}, // R11
    {OP_WR,  SA, 6'h24, 32'h0100_0000, 4'd10}, // R10
    {OP_IRQ, SA, 6'h00, 32'h0000_0001, 4'd10}, // R10
    {OP_WR,  SA, 6'h1C, 32'h0000_0000, 4'd1},  // R1
    {OP_PK,  SA, 6'h1C, 32'h1234_5678, 4'd1}   // R1
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put(input logic s, input logic [5:0] ad, input logic w, input logic r, input logic [31:0] d);
    if (!s) begin a_addr = ad; a_wr = w; a_rd = r; a_wdata = d; end
    else    begin b_addr = ad; b_wr = w; b_rd = r; b_wdata = d; end
  endtask

  task automatic idle();
    put(SA, 6'h00, 1'b0, 1'b0, 32'h0);
    put(SB, 6'h00, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic write(input logic s, input logic [5:0] ad, input logic [31:0] d);
    put(s, ad, 1'b1, 1'b0, d);
    @(negedge clk);
    idle();
  endtask

  task automatic peek(input logic s, input logic [5:0] ad, input logic [31:0] exp, input int req);
    put(s, ad, 1'b0, 1'b0, 32'h0);
    #1 check(req, s ? b_rdata : a_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [44:0] v;
      v = VEC[i];
      case (v[44:43])
        OP_WR: write(v[42], v[41:36], v[35:4]);
        OP_RD: begin
          put(v[42], v[41:36], 1'b0, 1'b1, 32'h0);
          #1 check(int'(v[3:0]), v[42] ? b_rdata : a_rdata, v[35:4]);
          @(negedge clk);
          idle();
        end
        OP_PK: peek(v[42], v[41:36], v[35:4], int'(v[3:0]));
        default: #1 check(int'(v[3:0]), {31'b0, v[42] ? b_irq : a_irq}, v[35:4]);
      endcase
    end
    @(negedge clk);

    // R9: B rings slot 0 while A clears that pending bit in the same cycle
    write(SB, 6'h24, 32'h0008_0000);
    write(SA, 6'h20, 32'h8000_0000);
    peek(SA, 6'h20, 32'h81F0_0000, 9);
    write(SA, 6'h20, 32'h8000_0000);
    peek(SA, 6'h20, 32'h01F0_0000, 8);
    @(negedge clk);

    // R6: new word for slot 3 arrives in the cycle A reads slot 3
    put(SA, 6'h1C, 1'b0, 1'b1, 32'h0);
    put(SB, 6'h0C, 1'b1, 1'b0, 32'h0000_A5A5);
    @(negedge clk);
    idle();
    peek(SA, 6'h20, 32'h01F0_0000, 6);
    peek(SA, 6'h1C, 32'h0000_A5A5, 6);
    @(negedge clk);
    put(SA, 6'h1C, 1'b0, 1'b1, 32'h0);
    #1 check(6, a_rdata, 32'h0000_A5A5);
    @(negedge clk);
    idle();
    peek(SA, 6'h20, 32'h00F0_0000, 6);
    @(negedge clk);
    @(negedge clk);
    peek(SB, 6'h20, 32'h00F0_0000, 6);
    @(negedge clk);

    // R4: reset during traffic
    write(SA, 6'h24, 32'hFFFF_FFFF);
    write(SB, 6'h04, 32'h0000_0077);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    peek(SA, 6'h20, 32'h00F0_0000, 4);
    peek(SA, 6'h24, 32'h0000_0000, 4);
    peek(SA, 6'h14, 32'h0000_0000, 4);
    #1 check(4, {31'b0, a_irq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule